// File: doc/BRIEF.md
# Pin Event Flag Unit

This unit watches a bank of already-synchronised input pins and turns selected level or edge conditions on them into sticky status flags. Every pin has its own control register holding a 4-bit condition code. The code either disables the pin, or makes it sense a low level, a high level, a rising edge, a falling edge or any edge. A pin whose condition is met sets its flag on the next clock edge. Software reads the flags from a single status register and clears them by writing ones there. Writing zeros to the status register leaves the flags as they are.

One request line is raised while any flag is pending. A level-sensed pin keeps setting its flag on every cycle its level holds, so clearing that flag does not drop the request until the pin level changes. Edge sensing compares each pin's present sample with the sample taken one clock earlier. Register access goes through a minimal write-strobe bus with a combinational read port.

Top module: `pin_event_flags`

## Requirements
- R1: After reset every control code is 0, every status flag is 0 and `irq_req` is low.
- R2: The control register for pin n sits at byte address 4·n. Its condition code is bits 19:16, and reading it back returns the code in those bits with every other bit 0.
- R3: Code 0x9 (rising edge) sets the pin's flag on the clock where the pin samples 1 after sampling 0 on the previous clock.
- R4: Code 0xA (falling edge) sets the flag on the clock where the pin samples 0 after sampling 1.
- R5: Code 0xB (either edge) sets the flag on any clock where the pin sample differs from the previous one.
- R6: Code 0x8 (low level) sets the flag on every clock the pin samples 0, so a cleared flag sets again while the pin stays low.
- R7: Code 0xC (high level) sets the flag on every clock the pin samples 1.
- R8: Code 0x0 and every code other than 0x8, 0x9, 0xA, 0xB and 0xC never set a flag.
- R9: The status register at address 0xA0 holds pin n's flag in bit n. Writing 1 to a bit clears that flag, writing 0 leaves it unchanged, and writing all ones clears every flag. A flag with no clear stays set.
- R10: When a clear and a new event hit the same pin in one clock, the flag is set afterwards.
- R11: `irq_req` is high exactly while at least one status flag is set (same cycle in the default configuration).
- R12: Writing a control register with code 0 stops that pin from setting new flags and leaves its existing flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_lvl | input | 32 | Synchronised pin levels |
| irq_req | output | 1 | Combined request, high while any flag is set |

## Verification
A pin change or register write driven during cycle c reaches the flags at the clock that ends c. It is therefore due in the status read and on `irq_req` one cycle later. Control readback is combinational and is due in the same cycle as the address. Writing a level code to a pin that already meets that level makes the flag appear one cycle later still, because the condition is evaluated with the old code on the clock that stores the new one. Each expected item carries the cycle in which it is due. The monitor compares each item only in that cycle, half a period after the edge, and fails any item that arrives late.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      MODE_OFF    = 4'h0,
      MODE_LVL_LO = 4'h8,
      MODE_RISE   = 4'h9,
      MODE_FALL   = 4'hA,
      MODE_BOTH   = 4'hB,
      MODE_LVL_HI = 4'hC
   } evt_mode_e;

   function automatic logic mode_known(input logic [MODE_W-1:0] code);
      return (code == MODE_LVL_LO) || (code == MODE_RISE) || (code == MODE_FALL) ||
             (code == MODE_BOTH)   || (code == MODE_LVL_HI);
   endfunction

endpackage

// File: rtl/pin_evt_cell.sv
module pin_evt_cell
   import pin_evt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl,
   input  logic              cfg_we,
   input  logic [MODE_W-1:0] cfg_wdata,
   input  logic              clr,
   output logic [MODE_W-1:0] cfg,
   output logic              hit,
   output logic              flag
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         prev_q <= 1'b0;
         flag   <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (cfg_we) cfg <= cfg_wdata;
         flag <= hit | (flag & ~clr);
      end
   end

   always_comb begin
      case (cfg)
         MODE_LVL_LO: hit = ~lvl;
         MODE_LVL_HI: hit = lvl;
         MODE_RISE:   hit = lvl & ~prev_q;
         MODE_FALL:   hit = ~lvl & prev_q;
         MODE_BOTH:   hit = lvl ^ prev_q;
         default:     hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/pin_evt_rdmux.sv
module pin_evt_rdmux
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int CFG_LSB     = 16,
   parameter int STRIDE      = 4,
   parameter int STATUS_ADDR = 'hA0
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_PINS*MODE_W-1:0] cfg_flat,
   input  logic [NUM_PINS-1:0]        flags,
   output logic [DATA_W-1:0]          rdata
);

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(STATUS_ADDR))
         rdata[NUM_PINS-1:0] = flags;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (addr == ADDR_W'(i * STRIDE))
            rdata[CFG_LSB +: MODE_W] = cfg_flat[i*MODE_W +: MODE_W];
      end
   end

endmodule

// File: rtl/pin_evt_merge.sv
module pin_evt_merge #(
   parameter int NUM_PINS = 32,
   parameter bit REG_OUT  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] flags,
   output logic                req
);

   if (REG_OUT) begin : g_reg
      logic req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= |flags;
      end
      assign req = req_q;
   end else begin : g_comb
      assign req = |flags;
   end

endmodule

// File: rtl/pin_event_flags.sv
module pin_event_flags
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int CFG_LSB     = 16,
   parameter int STATUS_ADDR = 'hA0,
   parameter bit REG_IRQ     = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_lvl,
   output logic                irq_req
);

   localparam int STRIDE  = 4;
   localparam int CFG_MSB = CFG_LSB + MODE_W - 1;

   if (NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must fit in one data word");
   end
   if (CFG_MSB >= DATA_W) begin : g_bad_field
      $error("condition field exceeds data width");
   end
   if (NUM_PINS * STRIDE > STATUS_ADDR) begin : g_bad_map
      $error("control registers overlap status register");
   end
   if (STATUS_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("status address exceeds address width");
   end

   logic                        stat_wr;
   logic [NUM_PINS-1:0]         flags;
   logic [NUM_PINS-1:0]         set_vec;
   logic [NUM_PINS-1:0]         clr_vec;
   logic [NUM_PINS*MODE_W-1:0]  cfg_flat;

   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(STATUS_ADDR));

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      logic sel;
      assign sel        = bus_wr && (bus_addr == ADDR_W'(g * STRIDE));
      assign clr_vec[g] = stat_wr & bus_wdata[g];

      pin_evt_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl       (pin_lvl[g]),
         .cfg_we    (sel),
         .cfg_wdata (bus_wdata[CFG_MSB:CFG_LSB]),
         .clr       (clr_vec[g]),
         .cfg       (cfg_flat[g*MODE_W +: MODE_W]),
         .hit       (set_vec[g]),
         .flag      (flags[g])
      );
   end

   pin_evt_rdmux #(
      .NUM_PINS    (NUM_PINS),
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .CFG_LSB     (CFG_LSB),
      .STRIDE      (STRIDE),
      .STATUS_ADDR (STATUS_ADDR)
   ) u_rdmux (
      .addr     (bus_addr),
      .cfg_flat (cfg_flat),
      .flags    (flags),
      .rdata    (bus_rdata)
   );

   pin_evt_merge #(
      .NUM_PINS (NUM_PINS),
      .REG_OUT  (REG_IRQ)
   ) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .req   (irq_req)
   );

endmodule

// File: rtl/pin_event_flags_chk.sv
module pin_event_flags_chk
   import pin_evt_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_PINS-1:0]        flags,
   input logic [NUM_PINS-1:0]        set_vec,
   input logic [NUM_PINS-1:0]        clr_vec,
   input logic [NUM_PINS*MODE_W-1:0] cfg_flat
);

   logic [NUM_PINS-1:0] known_mask;

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++)
         known_mask[i] = mode_known(cfg_flat[i*MODE_W +: MODE_W]);
   end

   // R9: a cleared pin with no new event is low on the next cycle
   assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_vec & ~set_vec)) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));

   // R9: an uncleared flag stays set
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|flags) |=> ((~flags & $past(flags & ~clr_vec)) == '0));

   // R10: every detected event leaves its flag set, whatever clear arrives with it
   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((~flags & $past(set_vec)) == '0));

   // R8 / R12: disabled or unknown codes never raise an event
   assert_unknown_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec & ~known_mask) == '0);

endmodule

bind pin_event_flags pin_event_flags_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flags    (flags),
   .set_vec  (set_vec),
   .clr_vec  (clr_vec),
   .cfg_flat (cfg_flat)
);

// File: tb/pin_event_flags_test.sv
module pin_event_flags_test;

   localparam logic [7:0] STAT = 8'hA0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = STAT;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pins = '0;
   logic        irq_req;

   always #10 clk = ~clk;   // 50 MHz

   pin_event_flags uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_lvl   (pins),
      .irq_req   (irq_req)
   );

   typedef struct {
      int          due;
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops items when due and compares half a period after the edge
   always @(negedge clk) begin
      item_t       it;
      logic [31:0] act;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         it  = sb.pop_front();
         act = it.is_irq ? {31'b0, irq_req} : bus_rdata;
         checks++;
         if (it.due != cyc || act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (due %0d, seen %0d)",
                     it.req, act, it.exp, it.due, cyc);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic push(input bit irq, input logic [31:0] e, input string r);
      sb.push_back('{cyc, irq, e, r});
   endtask

   task automatic chk_status(input logic [31:0] e, input string r);
      push(1'b0, e, r);
      push(1'b1, {31'b0, |e}, {r, " R11"});
      tick();
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      tick();
      bus_wr    = 1'b0;
      bus_addr  = STAT;
      bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
      bus_addr = a;
      push(1'b0, e, r);
      tick();
      bus_addr = STAT;
   endtask

   task automatic set_pins(input logic [31:0] v);
      pins = v;
      tick();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      chk_status(32'h0, "R1");
      rd(8'h14, 32'h0, "R1");

      wr(8'h00, 32'h0009_0000);   // pin0 rising
      wr(8'h04, 32'h000A_0000);   // pin1 falling
      wr(8'h08, 32'h000B_0000);   // pin2 either
      wr(8'h10, 32'h000C_0000);   // pin4 high level
      wr(8'h14, 32'h0005_0000);   // pin5 unknown code
      wr(8'h18, 32'hFFFF_FFFF);   // pin6 code F
      rd(8'h18, 32'h000F_0000, "R2");
      rd(8'h08, 32'h000B_0000, "R2");
      chk_status(32'h0, "R8");

      set_pins(32'h77);
      chk_status(32'h15, "R3 R5 R7 R8");
      chk_status(32'h15, "R7");

      wr(STAT, 32'h01);
      chk_status(32'h14, "R9");
      wr(STAT, 32'h00);
      chk_status(32'h14, "R9");
      wr(STAT, 32'h10);
      chk_status(32'h14, "R10");
      wr(STAT, 32'h04);
      chk_status(32'h10, "R9");

      set_pins(32'h0);
      chk_status(32'h16, "R4 R5");
      wr(STAT, 32'hFFFF_FFFF);
      chk_status(32'h0, "R9");

      wr(8'h0C, 32'h0008_0000);   // pin3 low level
      chk_status(32'h0, "R6");
      chk_status(32'h08, "R6");
      wr(STAT, 32'h08);
      chk_status(32'h08, "R6");
      set_pins(32'h08);
      chk_status(32'h08, "R9");
      wr(STAT, 32'h08);
      chk_status(32'h0, "R6");

      set_pins(32'h09);
      chk_status(32'h01, "R3");
      wr(8'h00, 32'h0);
      chk_status(32'h01, "R12");
      rd(8'h00, 32'h0, "R12");
      wr(STAT, 32'h01);
      chk_status(32'h0, "R9");
      set_pins(32'h08);
      set_pins(32'h09);
      chk_status(32'h0, "R12");

      wr(8'h7C, 32'h000B_0000);   // pin31 either
      rd(8'h7C, 32'h000B_0000, "R2");
      set_pins(32'h8000_0009);
      chk_status(32'h8000_0000, "R5");
      pins = 32'h0000_0009;       // falling edge in the same cycle as the clear
      wr(STAT, 32'h8000_0000);
      chk_status(32'h8000_0000, "R10");
      wr(STAT, 32'h8000_0000);
      chk_status(32'h0, "R9");

      repeat (3) tick();
      if (sb.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule